// File: doc/BRIEF.md
# Indexed Nibble-Store Execution Unit

This unit carries out a small family of 13-bit store instructions inside a 4-bit microcontroller datapath. Each store writes one nibble to data memory through one of two 16-bit index pointers, X or Y. Some forms copy accumulator A or B to memory and then step the pointer forward by one. Other forms write a 4-bit constant taken from the instruction itself. The surrounding core supplies the current A, B, X and Y values. The unit returns a memory write request and update requests for the index registers. All of these appear on registered outputs in the cycle after the instruction is accepted.

A prefix mechanism lets software send one constant store to a fixed 256-entry page. The `ext_load` input captures an 8-bit offset and arms a one-instruction prefix, which is visible on `e_flag`. If the next supported store is a constant store, it ignores its pointer. A constant store through X goes to page 0x00. A constant store through Y goes to page 0xFF. The pointer-increment form never uses the prefix, but it still disarms it.

A two-state controller tracks the prefix. In state `ST_PLAIN` no prefix is armed. In state `ST_ARMED` one is. The controller has three named transitions. ARM is taken on `ext_load` from either state. CONSUME goes from `ST_ARMED` to `ST_PLAIN` on any supported store with no simultaneous `ext_load`. HOLD keeps the state on idle cycles and on unsupported opcodes.

Top module: `nstore_unit`

## Requirements
- R1: A supported store presented with `instr_valid` at clock edge n raises `mem_we` during the cycle after edge n only. Without `instr_valid`, `mem_we` stays low in the next cycle.
- R2: The register-store opcodes are 0x1EE9, 0x1EEB, 0x1EED and 0x1EEF. Bit 1 of the instruction picks the pointer (0 = X, 1 = Y). Bit 2 picks the data (0 = A, 1 = B). The store writes the chosen register to the address held in the chosen pointer.
- R3: A register store requests an update of only the chosen pointer, with the value pointer + 1 modulo 2^16, so 0xFFFF becomes 0x0000.
- R4: The constant-store opcodes are 0x1E80–0x1E8F for X and 0x1EA0–0x1EAF for Y. Instruction bits 3:0 are the data. With no prefix armed, the address is the pointer value. No pointer update is requested.
- R5: With a prefix armed, a constant store through X writes to address 0x0000 + offset, where offset is the captured 8-bit value.
- R6: With a prefix armed, a constant store through Y writes to address 0xFF00 + offset.
- R7: With a prefix armed, a register store still uses the pointer address and still increments the pointer.
- R8: Every supported store without a simultaneous `ext_load` leaves `e_flag` low in the following cycle.
- R9: `ext_load` captures `ext_value` and makes `e_flag` high from the next cycle. An instruction in the same cycle uses the previous prefix state and offset.
- R10: An opcode outside the supported set produces no memory write and no pointer update, and it leaves `e_flag` unchanged.
- R11: After reset, `e_flag`, `mem_we`, `x_upd_en` and `y_upd_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 13 | Instruction word |
| reg_a | input | 4 | Accumulator A value |
| reg_b | input | 4 | Accumulator B value |
| reg_x | input | 16 | Index X value |
| reg_y | input | 16 | Index Y value |
| ext_load | input | 1 | Capture offset and arm prefix |
| ext_value | input | 8 | Prefix page offset |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 4 | Memory write nibble |
| x_upd_en | output | 1 | Index X update request |
| x_upd_val | output | 16 | New index X value |
| y_upd_en | output | 1 | Index Y update request |
| y_upd_val | output | 16 | New index Y value |
| e_flag | output | 1 | Prefix armed flag |

## Verification
The prefix state is the only state that lasts beyond one instruction. If it is wrong, the fault shows on `e_flag` one cycle after the edge that set it. A stale or lost prefix shows up on the next constant store, as an address in page 0x00 or 0xFF where the pointer value was expected, or the other way round. Decode faults appear one cycle after the instruction, as a missing or extra write, the wrong data nibble, or an update request on the wrong pointer. Wrap-around faults appear as a nonzero `x_upd_val` or `y_upd_val` after a store through a pointer holding 0xFFFF.

// File: rtl/nstore_pkg.sv
package nstore_pkg;

    localparam int OP_W  = 13;
    localparam int NIB_W = 4;

    // Register-store family: only bits 2 and 1 vary
    localparam logic [OP_W-1:0] REGST_MASK  = 13'h1FF9;
    localparam logic [OP_W-1:0] REGST_MATCH = 13'h1EE9;
    // Constant-store families: low nibble is data
    localparam logic [OP_W-1:0] IMMST_MASK  = 13'h1FF0;
    localparam logic [OP_W-1:0] IMMX_MATCH  = 13'h1E80;
    localparam logic [OP_W-1:0] IMMY_MATCH  = 13'h1EA0;

    localparam int SEL_PTR_BIT = 1;
    localparam int SEL_SRC_BIT = 2;

    typedef enum logic [1:0] {
        OPK_NONE  = 2'd0,
        OPK_REGST = 2'd1,
        OPK_IMMST = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e          kind;
        logic              use_y;
        logic              src_b;
        logic [NIB_W-1:0]  imm;
    } dec_t;

    typedef enum logic {
        ST_PLAIN = 1'b0,
        ST_ARMED = 1'b1
    } pfx_state_e;

endpackage

// File: rtl/nstore_decode.sv
module nstore_decode
    import nstore_pkg::*;
(
    input  logic [OP_W-1:0] instr,
    output dec_t            dec
);

    logic is_reg;
    logic is_immx;
    logic is_immy;

    assign is_reg  = (instr & REGST_MASK) == REGST_MATCH;
    assign is_immx = (instr & IMMST_MASK) == IMMX_MATCH;
    assign is_immy = (instr & IMMST_MASK) == IMMY_MATCH;

    always_comb begin
        dec       = '0;
        dec.kind  = OPK_NONE;
        dec.imm   = instr[NIB_W-1:0];
        if (is_reg) begin
            dec.kind  = OPK_REGST;
            dec.use_y = instr[SEL_PTR_BIT];
            dec.src_b = instr[SEL_SRC_BIT];
        end else if (is_immx || is_immy) begin
            dec.kind  = OPK_IMMST;
            dec.use_y = is_immy;
        end
    end

endmodule

// File: rtl/nstore_ctrl.sv
module nstore_ctrl
    import nstore_pkg::*;
#(
    parameter int EXT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec,
    input  logic             ext_load,
    input  logic [EXT_W-1:0] ext_value,
    output logic             armed,
    output logic [EXT_W-1:0] ext_q
);

    pfx_state_e state_q;
    pfx_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PLAIN;
        end else begin
            state_q <= state_d;
        end
    end

    // Offset register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else if (ext_load) begin
            ext_q <= ext_value;
        end
    end

    // Next state: ARM beats CONSUME, otherwise HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PLAIN: begin
                if (ext_load) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (ext_load)  state_d = ST_ARMED;
                else if (exec) state_d = ST_PLAIN;
            end
            default: state_d = ST_PLAIN;
        endcase
    end

    // Outputs
    always_comb begin
        armed = 1'b0;
        unique case (state_q)
            ST_PLAIN: armed = 1'b0;
            ST_ARMED: armed = 1'b1;
            default:  armed = 1'b0;
        endcase
    end

endmodule

// File: rtl/nstore_path.sv
module nstore_path
    import nstore_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int EXT_W  = 8
) (
    input  dec_t              dec,
    input  logic              armed,
    input  logic [EXT_W-1:0]  ext_q,
    input  logic [NIB_W-1:0]  reg_a,
    input  logic [NIB_W-1:0]  reg_b,
    input  logic [ADDR_W-1:0] reg_x,
    input  logic [ADDR_W-1:0] reg_y,
    output logic [ADDR_W-1:0] addr,
    output logic [NIB_W-1:0]  wdata,
    output logic              upd_x,
    output logic              upd_y,
    output logic [ADDR_W-1:0] next_x,
    output logic [ADDR_W-1:0] next_y
);

    localparam int PAGE_W = ADDR_W - EXT_W;

    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] page_addr;

    assign ptr = dec.use_y ? reg_y : reg_x;

    generate
        if (PAGE_W > 0) begin : g_paged
            assign page_addr = dec.use_y ? {{PAGE_W{1'b1}}, ext_q}
                                         : {{PAGE_W{1'b0}}, ext_q};
        end else begin : g_flat
            assign page_addr = ext_q[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        addr  = ptr;
        wdata = dec.imm;
        upd_x = 1'b0;
        upd_y = 1'b0;
        unique case (dec.kind)
            OPK_REGST: begin
                wdata = dec.src_b ? reg_b : reg_a;
                upd_x = !dec.use_y;
                upd_y = dec.use_y;
            end
            OPK_IMMST: begin
                if (armed) addr = page_addr;
            end
            default: ;
        endcase
    end

    assign next_x = reg_x + 1'b1;
    assign next_y = reg_y + 1'b1;

endmodule

// File: rtl/nstore_unit.sv
module nstore_unit
    import nstore_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int EXT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [12:0]       instr,
    input  logic [3:0]        reg_a,
    input  logic [3:0]        reg_b,
    input  logic [ADDR_W-1:0] reg_x,
    input  logic [ADDR_W-1:0] reg_y,
    input  logic              ext_load,
    input  logic [EXT_W-1:0]  ext_value,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_wdata,
    output logic              x_upd_en,
    output logic [ADDR_W-1:0] x_upd_val,
    output logic              y_upd_en,
    output logic [ADDR_W-1:0] y_upd_val,
    output logic              e_flag
);

    dec_t              dec;
    logic              exec;
    logic              armed;
    logic [EXT_W-1:0]  ext_q;
    logic [ADDR_W-1:0] addr_c;
    logic [NIB_W-1:0]  wdata_c;
    logic              upd_x_c;
    logic              upd_y_c;
    logic [ADDR_W-1:0] next_x_c;
    logic [ADDR_W-1:0] next_y_c;

    nstore_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign exec = instr_valid && (dec.kind != OPK_NONE);

    nstore_ctrl #(.EXT_W(EXT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec      (exec),
        .ext_load  (ext_load),
        .ext_value (ext_value),
        .armed     (armed),
        .ext_q     (ext_q)
    );

    nstore_path #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_path (
        .dec    (dec),
        .armed  (armed),
        .ext_q  (ext_q),
        .reg_a  (reg_a),
        .reg_b  (reg_b),
        .reg_x  (reg_x),
        .reg_y  (reg_y),
        .addr   (addr_c),
        .wdata  (wdata_c),
        .upd_x  (upd_x_c),
        .upd_y  (upd_y_c),
        .next_x (next_x_c),
        .next_y (next_y_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            x_upd_en  <= 1'b0;
            x_upd_val <= '0;
            y_upd_en  <= 1'b0;
            y_upd_val <= '0;
        end else begin
            mem_we    <= exec;
            mem_addr  <= addr_c;
            mem_wdata <= wdata_c;
            x_upd_en  <= exec && upd_x_c;
            x_upd_val <= next_x_c;
            y_upd_en  <= exec && upd_y_c;
            y_upd_val <= next_y_c;
        end
    end

    assign e_flag = armed;

endmodule

// File: rtl/nstore_unit_chk.sv
module nstore_unit_chk
    import nstore_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int EXT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [12:0]       instr,
    input logic [3:0]        reg_a,
    input logic [3:0]        reg_b,
    input logic [ADDR_W-1:0] reg_x,
    input logic [ADDR_W-1:0] reg_y,
    input logic              ext_load,
    input logic [EXT_W-1:0]  ext_q,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_wdata,
    input logic              x_upd_en,
    input logic [ADDR_W-1:0] x_upd_val,
    input logic              y_upd_en,
    input logic              e_flag
);

    logic c_reg;
    logic c_immx;
    logic c_immy;
    logic c_sup;

    assign c_reg  = (instr == 13'h1EE9) || (instr == 13'h1EEB) ||
                    (instr == 13'h1EED) || (instr == 13'h1EEF);
    assign c_immx = instr[12:4] == 9'h1E8;
    assign c_immy = instr[12:4] == 9'h1EA;
    assign c_sup  = c_reg || c_immx || c_immy;

    assert_store_writes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && c_sup |=> mem_we);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !mem_we && !x_upd_en && !y_upd_en);

    assert_reg_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && c_reg |=>
            mem_wdata == ($past(instr[2]) ? $past(reg_b) : $past(reg_a)));

    assert_postinc_x_R3: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && c_reg && !instr[1] |=>
            x_upd_en && !y_upd_en && x_upd_val == ADDR_W'($past(reg_x) + 1'b1));

    assert_one_pointer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({x_upd_en, y_upd_en}));

    assert_page_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && c_immx && e_flag |=>
            mem_addr == {{(ADDR_W-EXT_W){1'b0}}, $past(ext_q)});

    assert_page_y_R6: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && c_immy && e_flag |=>
            mem_addr == {{(ADDR_W-EXT_W){1'b1}}, $past(ext_q)});

    assert_reg_ignores_prefix_R7: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && c_reg && e_flag |=>
            mem_addr == ($past(instr[1]) ? $past(reg_y) : $past(reg_x)));

    assert_store_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && c_sup && !ext_load |=> !e_flag);

    assert_load_arms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_load |=> e_flag);

    assert_unsupported_R10: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && !c_sup && !ext_load |=>
            !mem_we && !x_upd_en && !y_upd_en && $stable(e_flag));

endmodule

bind nstore_unit nstore_unit_chk #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .reg_a       (reg_a),
    .reg_b       (reg_b),
    .reg_x       (reg_x),
    .reg_y       (reg_y),
    .ext_load    (ext_load),
    .ext_q       (ext_q),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .x_upd_en    (x_upd_en),
    .x_upd_val   (x_upd_val),
    .y_upd_en    (y_upd_en),
    .e_flag      (e_flag)
);

// File: tb/nstore_unit_test.sv
`timescale 1ns/1ps
module nstore_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [12:0] instr = '0;
    logic [3:0]  reg_a = '0;
    logic [3:0]  reg_b = '0;
    logic [15:0] reg_x = '0;
    logic [15:0] reg_y = '0;
    logic        ext_load = 1'b0;
    logic [7:0]  ext_value = '0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [3:0]  mem_wdata;
    logic        x_upd_en;
    logic [15:0] x_upd_val;
    logic        y_upd_en;
    logic [15:0] y_upd_val;
    logic        e_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    logic       m_e = 1'b0;
    logic [7:0] m_ext = '0;

    always #2 clk = ~clk;

    nstore_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .reg_a(reg_a), .reg_b(reg_b), .reg_x(reg_x), .reg_y(reg_y),
        .ext_load(ext_load), .ext_value(ext_value),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .x_upd_en(x_upd_en), .x_upd_val(x_upd_val),
        .y_upd_en(y_upd_en), .y_upd_val(y_upd_val), .e_flag(e_flag)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_reg_op(input logic [12:0] op);
        return op == 13'h1EE9 || op == 13'h1EEB || op == 13'h1EED || op == 13'h1EEF;
    endfunction

    function automatic bit is_immx_op(input logic [12:0] op);
        return op >= 13'h1E80 && op <= 13'h1E8F;
    endfunction

    function automatic bit is_immy_op(input logic [12:0] op);
        return op >= 13'h1EA0 && op <= 13'h1EAF;
    endfunction

    // Drive one cycle at the falling edge, check the results one falling edge later
    task automatic step(input logic v, input logic [12:0] op,
                        input logic ld, input logic [7:0] ev);
        bit          rg, ix, iy, we, ux, uy;
        logic [15:0] ea;
        logic [3:0]  ed;
        string       tag;
        instr_valid = v; instr = op; ext_load = ld; ext_value = ev;
        rg = v && is_reg_op(op);
        ix = v && is_immx_op(op);
        iy = v && is_immy_op(op);
        we = rg || ix || iy;
        ux = rg && !op[1];
        uy = rg && op[1];
        ea = 16'h0; ed = 4'h0; tag = "R1";
        if (rg) begin
            ea  = op[1] ? reg_y : reg_x;
            ed  = op[2] ? reg_b : reg_a;
            tag = m_e ? "R7" : "R2";
        end else if (ix) begin
            ea  = m_e ? {8'h00, m_ext} : reg_x;
            ed  = op[3:0];
            tag = m_e ? "R5" : "R4";
        end else if (iy) begin
            ea  = m_e ? {8'hFF, m_ext} : reg_y;
            ed  = op[3:0];
            tag = m_e ? "R6" : "R4";
        end else if (v) begin
            tag = "R10";
        end
        begin
            logic [15:0] ex_x = reg_x + 16'd1;
            logic [15:0] ex_y = reg_y + 16'd1;
            @(posedge clk);
            @(negedge clk);
            chk(tag, "mem_we", 32'(mem_we), 32'(we));
            if (we) begin
                chk(tag, "mem_addr", 32'(mem_addr), 32'(ea));
                chk(tag, "mem_wdata", 32'(mem_wdata), 32'(ed));
            end
            chk("R3", "x_upd_en", 32'(x_upd_en), 32'(ux));
            chk("R3", "y_upd_en", 32'(y_upd_en), 32'(uy));
            if (ux) chk("R3", "x_upd_val", 32'(x_upd_val), 32'(ex_x));
            if (uy) chk("R3", "y_upd_val", 32'(y_upd_val), 32'(ex_y));
        end
        m_e   = ld ? 1'b1 : (we ? 1'b0 : m_e);
        m_ext = ld ? ev : m_ext;
        chk(ld ? "R9" : (we ? "R8" : "R10"), "e_flag", 32'(e_flag), 32'(m_e));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "mem_we", 32'(mem_we), 0);
        chk("R11", "e_flag", 32'(e_flag), 0);
        chk("R11", "x_upd_en", 32'(x_upd_en), 0);
        chk("R11", "y_upd_en", 32'(y_upd_en), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases
        reg_a = 4'h3; reg_b = 4'hC; reg_x = 16'h1234; reg_y = 16'hFFFF;
        step(1, 13'h1EE9, 0, 8'h00);          // R2: A through X
        step(1, 13'h1EEF, 0, 8'h00);          // R3: B through Y, wrap
        reg_x = 16'hFFFF;
        step(1, 13'h1EE9, 0, 8'h00);          // R3: X wrap
        step(1, 13'h1E87, 0, 8'h00);          // R4: constant via X
        step(0, 13'h0000, 1, 8'h5A);          // R9: arm
        step(1, 13'h1E8B, 0, 8'h00);          // R5
        step(0, 13'h0000, 1, 8'hC3);
        step(1, 13'h1EA4, 0, 8'h00);          // R6
        step(0, 13'h0000, 1, 8'h77);
        reg_x = 16'h4321;
        step(1, 13'h1EED, 0, 8'h00);          // R7, R8
        step(0, 13'h0000, 1, 8'hFF);
        step(1, 13'h1EE8, 0, 8'h00);          // R10: near-miss opcode
        step(1, 13'h1E90, 0, 8'h00);          // R10
        step(1, 13'h1E8F, 0, 8'h00);          // R5: page 0x00FF
        step(1, 13'h1E81, 1, 8'h10);          // R9: same-cycle load, old prefix clear
        step(1, 13'h1EAF, 0, 8'h00);          // R6 with new offset
        step(0, 13'h1EE9, 0, 8'h00);          // R1: no strobe

        // Constrained random
        for (int i = 0; i < 3000; i++) begin
            int          r;
            logic [12:0] op;
            logic        v;
            logic        ld;
            r = $urandom % 10;
            reg_a = 4'($urandom); reg_b = 4'($urandom);
            reg_x = ($urandom % 8 == 0) ? 16'hFFFF : 16'($urandom);
            reg_y = ($urandom % 8 == 0) ? 16'hFFFF : 16'($urandom);
            v = 1'b1; ld = 1'b0;
            if (r < 3)      op = 13'h1EE9 | 13'(($urandom % 4) << 1);
            else if (r < 6) op = (($urandom % 2) ? 13'h1EA0 : 13'h1E80) | 13'($urandom % 16);
            else if (r < 7) op = 13'($urandom);
            else if (r < 8) begin op = 13'($urandom); v = 1'($urandom); ld = 1'b1; end
            else begin op = 13'($urandom); v = 1'b0; end
            step(v, op, ld, 8'($urandom));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule